// File: doc/BRIEF.md
# Diverge Branch Predication Mode Controller

This block sits in a processor front end. It decides when fetch leaves ordinary single-path operation and enters a dynamic predication mode. In that mode, both outcomes of a hard-to-predict branch are fetched until they meet again at a merge point that the compiler has marked. Each fetched branch carries a two-bit kind code and a signed relative offset. For a diverge branch that the confidence estimator flags as low confidence, the controller takes these steps:
- It computes the merge address from that offset and latches it.
- It takes a predicate id from a small pool.
- It pulses fork strobes so the return stack, the global history and the register alias table can make their second copies.

While the mode is active, the controller picks which of the two paths uses each fetch slot. It also watches for each path reaching the merge address. The mode ends in one of four ways, each marked by its own one-cycle pulse:
- both paths arrive at the merge address;
- the diverge branch resolves;
- too many instructions are fetched;
- a younger low-confidence diverge branch appears, which takes over the mode.

When the branch resolves while both paths are still in flight, a flush request names the wrong path.

Top module: `pred_mode_ctrl`

## Requirements
- R1: Kind codes 2'b10 (forward diverge) and 2'b11 (loop diverge) are diverge branches. Codes 2'b00 (normal) and 2'b01 never start predication.
- R2: The merge address is the branch PC plus the sign-extended relative field, modulo 2^AW. It appears on merge_pc from the cycle after entry and holds steady until the mode is left or re-entered.
- R3: Entry needs br_valid, a diverge kind, br_low_conf and a free predicate id. On the clock edge of entry, pred_mode rises and fork_ras, fork_ghr and fork_rat pulse high for exactly one cycle.
- R4: Each entry takes the lowest-numbered free predicate id and shows it on pred_id. An id stays reserved until it is released as R8, R9, R10 or R11 describe.
- R5: fetch_path is 0 in the first cycle of the mode. It toggles every cycle while neither path has fetched the merge address.
- R6: A path has arrived once a fetch_valid slot on it carries fetch_pc equal to merge_pc. After one path arrives, fetch_path stays on the other path every cycle.
- R7: When the second path arrives, merge_done pulses for one cycle and pred_mode falls. The predicate id stays reserved until its branch resolves.
- R8: A resolve whose resolve_id equals the active pred_id ends the mode, frees the id and pulses flush_req. flush_path is the inverse of resolve_path, where resolve_path 0 means the first path and 1 the second. This has the highest priority.
- R9: A resolve of a reserved id that is not active, such as one whose paths already merged, frees the id and gives no flush. A resolve of a free id changes nothing.
- R10: A fetch_valid slot in the mode that would push the fetch count above limit_thresh ends the mode with a one-cycle limit_pulse and frees the id. Its priority is below resolve and above yield and arrival.
- R11: A low-confidence diverge branch fetched during the mode frees the current id and re-enters. The new entry gives a yield_pulse, new fork pulses, a new merge address and id, a restarted fetch count and fetch_path 0.
- R12: During the mode, branches that are high confidence or of a normal kind leave merge_pc, pred_id and pred_mode unchanged and give no fork pulse.
- R13: With every id reserved, a low-confidence diverge branch is handled as a normal branch: no entry and no fork.
- R14: After reset, pred_mode, fetch_path, flush_req, merge_done and all fork strobes are 0, and every predicate id is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch is fetched in this slot |
| br_kind | input | 2 | Branch kind code |
| br_pc | input | AW | Address of the fetched branch |
| br_rel | input | RW | Signed offset to the merge point |
| br_low_conf | input | 1 | Confidence estimator flags the branch as low confidence |
| fetch_valid | input | 1 | An instruction is fetched on the selected path in this slot |
| fetch_pc | input | AW | Address of that instruction |
| resolve_valid | input | 1 | A diverge branch resolves |
| resolve_id | input | IDW | Predicate id of the resolving branch |
| resolve_path | input | 1 | Correct path, 0 = first, 1 = second |
| limit_thresh | input | CW | Largest fetch count allowed in the mode |
| pred_mode | output | 1 | Predication mode active |
| fetch_path | output | 1 | Path that owns the current fetch slot |
| merge_pc | output | AW | Latched merge address |
| pred_id | output | IDW | Predicate id of the active mode |
| fork_ras | output | 1 | Fork strobe for the return stack |
| fork_ghr | output | 1 | Fork strobe for global history |
| fork_rat | output | 1 | Fork strobe for the alias table |
| merge_done | output | 1 | Both paths reached the merge address |
| limit_pulse | output | 1 | Mode aborted on the fetch-count limit |
| yield_pulse | output | 1 | Mode handed to a younger diverge branch |
| flush_req | output | 1 | Flush request for wrong-path instructions |
| flush_path | output | 1 | Path to be flushed |

## Verification
A table walk tries every kind code, with and without low confidence. It uses positive offsets, negative offsets and an offset that wraps past the top of the address space. This separates the decode of the kind code, the confidence gate and the sign handling of the merge adder. Directed sequences do the following:
- They feed the two paths fetch addresses that miss, then hit, the merge address. This separates plain alternation from the stall of an arrived path.
- They issue resolves against active, merged and free ids to tell the three release cases apart.
- They count fetches across a yield to show that the count restarts.
- They fill the id pool with merged entries to show that an empty pool turns a diverge branch into a normal one.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        BK_NORMAL   = 2'b00,
        BK_RESERVED = 2'b01,
        BK_DIV_FWD  = 2'b10,
        BK_DIV_LOOP = 2'b11
    } br_kind_e;

    typedef enum logic [2:0] {
        EX_NONE,
        EX_RESOLVE,
        EX_LIMIT,
        EX_YIELD,
        EX_MERGE
    } exit_cause_e;

    localparam logic PATH_FIRST  = 1'b0;
    localparam logic PATH_SECOND = 1'b1;

    function automatic logic kind_is_diverge(input br_kind_e k);
        return (k == BK_DIV_FWD) || (k == BK_DIV_LOOP);
    endfunction

endpackage

// File: rtl/pmc_decode.sv
module pmc_decode
    import pmc_pkg::*;
#(
    parameter int AW = 32,
    parameter int RW = 16
) (
    input  logic          br_valid,
    input  logic [1:0]    br_kind,
    input  logic [AW-1:0] br_pc,
    input  logic [RW-1:0] br_rel,
    input  logic          br_low_conf,
    output logic          want_pred,
    output logic [AW-1:0] target
);
    localparam int EXT = AW - RW;

    br_kind_e kind;
    logic [AW-1:0] rel_ext;

    always_comb begin
        kind    = br_kind_e'(br_kind);
        rel_ext = {{EXT{br_rel[RW-1]}}, br_rel};
        target  = br_pc + rel_ext;
        want_pred = br_valid && br_low_conf && kind_is_diverge(kind);
    end

endmodule

// File: rtl/pmc_id_pool.sv
module pmc_id_pool #(
    parameter int NUM_IDS = 32,
    parameter int IDW     = $clog2(NUM_IDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_en,
    input  logic               rel_a_en,
    input  logic [IDW-1:0]     rel_a_id,
    input  logic               rel_b_en,
    input  logic [IDW-1:0]     rel_b_id,
    output logic               avail,
    output logic [IDW-1:0]     alloc_id,
    output logic [NUM_IDS-1:0] held_mask
);
    logic [NUM_IDS-1:0] free_q;
    logic [NUM_IDS-1:0] mask_eff;

    // Same-cycle releases are visible to the allocator.
    always_comb begin
        mask_eff = free_q;
        if (rel_a_en) mask_eff[rel_a_id] = 1'b1;
        if (rel_b_en) mask_eff[rel_b_id] = 1'b1;
        alloc_id = '0;
        for (int i = NUM_IDS - 1; i >= 0; i--) begin
            if (mask_eff[i]) alloc_id = IDW'(i);
        end
    end

    assign avail     = |mask_eff;
    assign held_mask = ~free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= '1;
        end else begin
            free_q <= mask_eff;
            if (alloc_en) free_q[alloc_id] <= 1'b0;
        end
    end

endmodule

// File: rtl/pmc_path_sel.sv
module pmc_path_sel
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic arrive,
    output logic path,
    output logic both_now
);
    logic       path_q;
    logic [1:0] arr_q;
    logic [1:0] arr_n;
    logic       path_n;

    always_comb begin
        arr_n = arr_q;
        if (arrive) arr_n[path_q] = 1'b1;
        both_now = &arr_n;
        unique case (arr_n)
            2'b01:   path_n = PATH_SECOND;
            2'b10:   path_n = PATH_FIRST;
            default: path_n = ~path_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= PATH_FIRST;
            arr_q  <= 2'b00;
        end else if (start) begin
            path_q <= PATH_FIRST;
            arr_q  <= 2'b00;
        end else if (active) begin
            path_q <= path_n;
            arr_q  <= arr_n;
        end else begin
            path_q <= PATH_FIRST;
            arr_q  <= 2'b00;
        end
    end

    assign path = path_q;

endmodule

// File: rtl/pred_mode_ctrl.sv
module pred_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int RW      = 16,
    parameter int CW      = 16,
    parameter int NUM_IDS = 32,
    localparam int IDW    = $clog2(NUM_IDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           br_valid,
    input  logic [1:0]     br_kind,
    input  logic [AW-1:0]  br_pc,
    input  logic [RW-1:0]  br_rel,
    input  logic           br_low_conf,
    input  logic           fetch_valid,
    input  logic [AW-1:0]  fetch_pc,
    input  logic           resolve_valid,
    input  logic [IDW-1:0] resolve_id,
    input  logic           resolve_path,
    input  logic [CW-1:0]  limit_thresh,
    output logic           pred_mode,
    output logic           fetch_path,
    output logic [AW-1:0]  merge_pc,
    output logic [IDW-1:0] pred_id,
    output logic           fork_ras,
    output logic           fork_ghr,
    output logic           fork_rat,
    output logic           merge_done,
    output logic           limit_pulse,
    output logic           yield_pulse,
    output logic           flush_req,
    output logic           flush_path
);
    logic               mode_q;
    logic [AW-1:0]      merge_q;
    logic [IDW-1:0]     pid_q;
    logic [CW-1:0]      cnt_q;
    logic               fork_q, merge_done_q, limit_q, yield_q, flush_q, flush_path_q;

    logic               want_pred;
    logic [AW-1:0]      target;
    logic               avail;
    logic [IDW-1:0]     alloc_id;
    logic [NUM_IDS-1:0] held_mask;
    logic               both_now;
    logic               cur_path;

    logic        res_active, res_held, cnt_over, arrive;
    logic        do_enter, do_yield, do_merge, leaving;
    exit_cause_e cause;

    pmc_decode #(.AW(AW), .RW(RW)) u_decode (
        .br_valid    (br_valid),
        .br_kind     (br_kind),
        .br_pc       (br_pc),
        .br_rel      (br_rel),
        .br_low_conf (br_low_conf),
        .want_pred   (want_pred),
        .target      (target)
    );

    // Priority: resolve of active id, fetch limit, yield, merge arrival.
    always_comb begin
        res_active = mode_q && resolve_valid && (resolve_id == pid_q);
        res_held   = resolve_valid && !res_active && held_mask[resolve_id];
        cnt_over   = mode_q && fetch_valid && (cnt_q >= limit_thresh);
        arrive     = 1'b0;
        cause      = EX_NONE;
        if (mode_q) begin
            if (res_active) begin
                cause = EX_RESOLVE;
            end else if (cnt_over) begin
                cause = EX_LIMIT;
            end else if (want_pred) begin
                cause = EX_YIELD;
            end else begin
                arrive = fetch_valid && (fetch_pc == merge_q);
                if (arrive && both_now) cause = EX_MERGE;
            end
        end
        do_yield = (cause == EX_YIELD);
        do_merge = (cause == EX_MERGE);
        leaving  = (cause == EX_RESOLVE) || (cause == EX_LIMIT) || do_merge;
        do_enter = !mode_q && want_pred && avail;
    end

    pmc_id_pool #(.NUM_IDS(NUM_IDS), .IDW(IDW)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (do_enter || do_yield),
        .rel_a_en  (res_active || res_held),
        .rel_a_id  (resolve_id),
        .rel_b_en  (cnt_over || do_yield),
        .rel_b_id  (pid_q),
        .avail     (avail),
        .alloc_id  (alloc_id),
        .held_mask (held_mask)
    );

    pmc_path_sel u_path (
        .clk      (clk),
        .rst      (rst),
        .start    (do_enter || do_yield),
        .active   (mode_q && !leaving),
        .arrive   (arrive),
        .path     (cur_path),
        .both_now (both_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            merge_q <= '0;
            pid_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (do_enter || do_yield) begin
                mode_q  <= 1'b1;
                merge_q <= target;
                pid_q   <= alloc_id;
                cnt_q   <= '0;
            end else if (leaving) begin
                mode_q <= 1'b0;
                cnt_q  <= '0;
            end else if (mode_q && fetch_valid) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fork_q       <= 1'b0;
            merge_done_q <= 1'b0;
            limit_q      <= 1'b0;
            yield_q      <= 1'b0;
            flush_q      <= 1'b0;
            flush_path_q <= 1'b0;
        end else begin
            fork_q       <= do_enter || do_yield;
            merge_done_q <= do_merge;
            limit_q      <= (cause == EX_LIMIT);
            yield_q      <= do_yield;
            flush_q      <= (cause == EX_RESOLVE);
            if (cause == EX_RESOLVE) flush_path_q <= ~resolve_path;
        end
    end

    assign pred_mode   = mode_q;
    assign fetch_path  = cur_path;
    assign merge_pc    = merge_q;
    assign pred_id     = pid_q;
    assign fork_ras    = fork_q;
    assign fork_ghr    = fork_q;
    assign fork_rat    = fork_q;
    assign merge_done  = merge_done_q;
    assign limit_pulse = limit_q;
    assign yield_pulse = yield_q;
    assign flush_req   = flush_q;
    assign flush_path  = flush_path_q;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int AW  = 32,
    parameter int IDW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           pred_mode,
    input logic [AW-1:0]  merge_pc,
    input logic [IDW-1:0] pred_id,
    input logic           fork_ras,
    input logic           fork_ghr,
    input logic           fork_rat,
    input logic           merge_done,
    input logic           limit_pulse,
    input logic           yield_pulse,
    input logic           flush_req
);
    assert_fork_on_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pred_mode) |-> (fork_ras && fork_ghr && fork_rat));

    assert_fork_only_in_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (fork_ras || fork_ghr || fork_rat) |-> pred_mode);

    assert_merge_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (pred_mode && $past(pred_mode) && !fork_rat) |-> $stable(merge_pc));

    assert_id_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (pred_mode && $past(pred_mode) && !fork_rat) |-> $stable(pred_id));

    assert_merge_exit_R7: assert property (@(posedge clk) disable iff (rst)
        merge_done |-> (!pred_mode && $past(pred_mode)));

    assert_flush_exit_R8: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (!pred_mode && $past(pred_mode)));

    assert_one_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({merge_done, flush_req, limit_pulse, yield_pulse}));

    assert_yield_reenter_R11: assert property (@(posedge clk) disable iff (rst)
        yield_pulse |-> (pred_mode && fork_rat));

endmodule

bind pred_mode_ctrl pmc_checker #(.AW(AW), .IDW(IDW)) u_pmc_chk (
    .clk         (clk),
    .rst         (rst),
    .pred_mode   (pred_mode),
    .merge_pc    (merge_pc),
    .pred_id     (pred_id),
    .fork_ras    (fork_ras),
    .fork_ghr    (fork_ghr),
    .fork_rat    (fork_rat),
    .merge_done  (merge_done),
    .limit_pulse (limit_pulse),
    .yield_pulse (yield_pulse),
    .flush_req   (flush_req)
);

// File: tb/tb_pred_mode_ctrl.sv
module tb_pred_mode_ctrl;
    localparam int T_AW  = 32;
    localparam int T_RW  = 16;
    localparam int T_CW  = 16;
    localparam int T_IDS = 4;
    localparam int T_IDW = $clog2(T_IDS);

    logic             clk = 1'b0;
    logic             rst;
    logic             br_valid, br_low_conf, fetch_valid, resolve_valid, resolve_path;
    logic [1:0]       br_kind;
    logic [T_AW-1:0]  br_pc, fetch_pc;
    logic [T_RW-1:0]  br_rel;
    logic [T_IDW-1:0] resolve_id;
    logic [T_CW-1:0]  limit_thresh;
    logic             pred_mode, fetch_path, fork_ras, fork_ghr, fork_rat;
    logic             merge_done, limit_pulse, yield_pulse, flush_req, flush_path;
    logic [T_AW-1:0]  merge_pc;
    logic [T_IDW-1:0] pred_id;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pred_mode_ctrl #(.AW(T_AW), .RW(T_RW), .CW(T_CW), .NUM_IDS(T_IDS)) dut (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_kind(br_kind), .br_pc(br_pc),
        .br_rel(br_rel), .br_low_conf(br_low_conf), .fetch_valid(fetch_valid),
        .fetch_pc(fetch_pc), .resolve_valid(resolve_valid), .resolve_id(resolve_id),
        .resolve_path(resolve_path), .limit_thresh(limit_thresh), .pred_mode(pred_mode),
        .fetch_path(fetch_path), .merge_pc(merge_pc), .pred_id(pred_id),
        .fork_ras(fork_ras), .fork_ghr(fork_ghr), .fork_rat(fork_rat),
        .merge_done(merge_done), .limit_pulse(limit_pulse), .yield_pulse(yield_pulse),
        .flush_req(flush_req), .flush_path(flush_path)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] pc;
        logic [15:0] rel;
        logic        lc;
        logic        exp_mode;
        logic [31:0] exp_merge;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b00, 32'h0000_1000, 16'h0040, 1'b1, 1'b0, 32'h0},
        '{2'b10, 32'h0000_1000, 16'h0040, 1'b1, 1'b1, 32'h0000_1040},
        '{2'b11, 32'h0000_2000, 16'hFFF0, 1'b1, 1'b1, 32'h0000_1FF0},
        '{2'b10, 32'h0000_3000, 16'h0010, 1'b0, 1'b0, 32'h0},
        '{2'b01, 32'h0000_3000, 16'h0010, 1'b1, 1'b0, 32'h0},
        '{2'b11, 32'hFFFF_FFF0, 16'h0020, 1'b1, 1'b1, 32'h0000_0010}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        br_valid = 0; br_kind = 2'b00; br_pc = '0; br_rel = '0; br_low_conf = 0;
        fetch_valid = 0; fetch_pc = '0;
        resolve_valid = 0; resolve_id = '0; resolve_path = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic branch(input logic [1:0] k, input logic [31:0] pc, input logic [15:0] rel,
                          input logic lc);
        quiet();
        br_valid = 1; br_kind = k; br_pc = pc; br_rel = rel; br_low_conf = lc;
        fetch_valid = 1; fetch_pc = pc;
    endtask

    task automatic fetch(input logic [31:0] pc);
        quiet();
        fetch_valid = 1; fetch_pc = pc;
    endtask

    task automatic resolve(input logic [T_IDW-1:0] id, input logic p);
        quiet();
        resolve_valid = 1; resolve_id = id; resolve_path = p;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        quiet();
        limit_thresh = 16'd100;
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        // R14 reset state
        chk("R14 mode", pred_mode, 0);
        chk("R14 path", fetch_path, 0);
        chk("R14 flush", flush_req, 0);
        chk("R14 merge_done", merge_done, 0);
        chk("R14 fork", {fork_ras, fork_ghr, fork_rat}, 0);

        // Table walk: R1 decode, R2 merge address, R3 entry, R8 flush
        for (int i = 0; i < 6; i++) begin
            branch(VECS[i].kind, VECS[i].pc, VECS[i].rel, VECS[i].lc);
            tick();
            chk("R1 entry by kind", pred_mode, VECS[i].exp_mode);
            if (VECS[i].exp_mode) begin
                chk("R2 merge addr", merge_pc, VECS[i].exp_merge);
                chk("R3 fork pulse", {fork_ras, fork_ghr, fork_rat}, 3'b111);
                chk("R4 first id", pred_id, 0);
                resolve(0, 1'b0);
                tick();
                chk("R8 flush", flush_req, 1);
                chk("R8 flush path", flush_path, 1);
                chk("R8 mode off", pred_mode, 0);
                chk("R3 fork one cycle", fork_rat, 0);
            end else begin
                chk("R3 no fork", fork_rat, 0);
                quiet();
                tick();
            end
        end

        // R5/R6/R7 alternation, stall and merge
        branch(2'b10, 32'h100, 16'h20, 1);
        tick();
        chk("R5 first path", fetch_path, 0);
        chk("R4 id", pred_id, 0);
        fetch(32'h104); tick();
        chk("R5 toggle", fetch_path, 1);
        fetch(32'h124); tick();
        chk("R5 toggle back", fetch_path, 0);
        fetch(32'h120); tick();
        chk("R6 after arrival", fetch_path, 1);
        chk("R6 mode kept", pred_mode, 1);
        fetch(32'h128); tick();
        chk("R6 stall", fetch_path, 1);
        fetch(32'h120); tick();
        chk("R7 merge pulse", merge_done, 1);
        chk("R7 mode off", pred_mode, 0);
        quiet(); tick();
        chk("R7 pulse one cycle", merge_done, 0);
        branch(2'b10, 32'h200, 16'h40, 1); tick();
        chk("R7 id still held", pred_id, 1);
        resolve(0, 1'b0); tick();
        chk("R9 no flush after merge", flush_req, 0);
        chk("R9 active mode kept", pred_mode, 1);
        resolve(1, 1'b1); tick();
        chk("R8 flush", flush_req, 1);
        chk("R8 flush path", flush_path, 0);
        branch(2'b10, 32'h300, 16'h8, 1); tick();
        chk("R9 id freed", pred_id, 0);
        resolve(0, 1'b0); tick();

        // R10 fetch limit
        limit_thresh = 16'd3;
        branch(2'b10, 32'h400, 16'h80, 1); tick();
        for (int k = 0; k < 3; k++) begin
            fetch(32'h404 + 32'(k * 4)); tick();
            chk("R10 within limit", pred_mode, 1);
        end
        fetch(32'h410); tick();
        chk("R10 limit pulse", limit_pulse, 1);
        chk("R10 mode off", pred_mode, 0);
        limit_thresh = 16'd100;

        // R12 ignored branches, R11 yield
        branch(2'b10, 32'h500, 16'h20, 1); tick();
        chk("R10 id freed", pred_id, 0);
        branch(2'b10, 32'h504, 16'h10, 0); tick();
        chk("R12 high conf merge", merge_pc, 32'h520);
        chk("R12 no fork", fork_rat, 0);
        branch(2'b00, 32'h50c, 16'h10, 1); tick();
        chk("R12 normal merge", merge_pc, 32'h520);
        chk("R12 mode", pred_mode, 1);
        branch(2'b11, 32'h508, 16'h30, 1); tick();
        chk("R11 yield pulse", yield_pulse, 1);
        chk("R11 fork", fork_rat, 1);
        chk("R11 new merge", merge_pc, 32'h538);
        chk("R11 path", fetch_path, 0);
        limit_thresh = 16'd2;
        fetch(32'h50c); tick();
        fetch(32'h510); tick();
        chk("R11 count restarted", pred_mode, 1);
        fetch(32'h514); tick();
        chk("R11 limit after restart", limit_pulse, 1);
        limit_thresh = 16'd100;

        // R9 resolve of free id has no effect
        resolve(3, 1'b0); tick();
        chk("R9 free id no flush", flush_req, 0);
        chk("R9 free id mode", pred_mode, 0);

        // R13 pool exhaustion
        for (int n = 0; n < 4; n++) begin
            branch(2'b10, 32'h1000 * (n + 1), 16'h10, 1); tick();
            chk("R4 sequential id", pred_id, n);
            fetch(32'h1000 * (n + 1) + 32'h10); tick();
            fetch(32'h1000 * (n + 1) + 32'h10); tick();
            chk("R7 merged", merge_done, 1);
        end
        branch(2'b10, 32'h9000, 16'h10, 1); tick();
        chk("R13 no entry", pred_mode, 0);
        chk("R13 no fork", fork_rat, 0);
        resolve(2, 1'b0); tick();
        chk("R9 merged id no flush", flush_req, 0);
        branch(2'b11, 32'h9100, 16'h10, 1); tick();
        chk("R13 entry after free", pred_mode, 1);
        chk("R4 reused id", pred_id, 2);
        resolve(2, 1'b0); tick();
        chk("R8 final flush", flush_req, 1);
        quiet(); tick();

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule